// File: doc/BRIEF.md
# Four-way write-through data cache

This block is a four-way set-associative cache that sits between a processor load/store port and a word-wide memory port. On each cacheable access it compares the addressed set in all four ways at once. A read hit is answered from the cache. A read miss pulls the whole line from memory into a way chosen by an external replacement selector, then returns the requested data. A write that hits merges its byte, halfword or word into the cached line. A write that misses leaves the cache untouched. The block never writes to memory: the write-through path lives outside it.

Each stored tag entry packs the line address, the number of the way that holds it, and a valid bit. An access with the cacheable input low skips the lookup entirely. Three maintenance operations clear valid bits: everything at once, the single line that matches a given line address, or one entry named by set and way.

Top module: `wt_cache`

## Requirements
- R1: A cacheable read whose line is valid in one way returns its data with no memory request, and `cpu_ready` pulses for that access.
- R2: A cacheable read miss issues exactly LINE_WORDS (default 8) memory reads. They start at the line-aligned base and step up by 4 bytes. The first read has `mem_seq` low and every later one has it high. `mem_addr` is held until `mem_ack`.
- R3: After a fill, the access returns the requested word of the new line, and later reads anywhere in that line hit.
- R4: `cpu_size` 0 selects a byte read. The result is the looked-up word shifted right by 8 × `cpu_addr[1:0]`, masked to 8 bits and zero-extended.
- R5: `cpu_size` 1 selects a halfword read, which is the word shifted right by 8 × (`cpu_addr` & 2) and masked to 16 bits. `cpu_size` 2 returns the whole word.
- R6: A cacheable write hit updates only the addressed lanes, with no memory traffic. A byte write uses lane `cpu_addr[1:0]` and `cpu_wdata[7:0]`. A halfword write uses lanes 1:0 or 3:2 as picked by `cpu_addr[1]`, with `cpu_wdata[15:0]`. A word write uses all lanes.
- R7: A cacheable write miss changes nothing: a later read of that address misses and returns memory data.
- R8: With `cpu_cacheable` low there is no lookup. A read does one nonsequential word read at the word-aligned address and returns its lanes. A write does nothing. Cached lines are unchanged either way.
- R9: `inv_all` and reset both clear every valid bit, so every later read misses.
- R10: `inv_addr_req` clears the valid bit only in the way whose stored line equals `inv_line`. Other ways of that set keep hitting.
- R11: `inv_sw_req` clears the entry at `inv_set` in way `inv_way`. A way number of 4 or more changes nothing.
- R12: `cpu_ready` is low in reset and is a one-cycle pulse raised once per access, after a lookup or after the memory transfer completes.
- R13: A fill writes only the way that `victim_way` named at miss time. Lines held in other ways stay valid, and at most one way hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_cacheable | input | 1 | Region allows caching for this access |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with `cpu_ready` |
| victim_way | input | 2 | Way to refill on a read miss |
| mem_req | output | 1 | Memory read request |
| mem_seq | output | 1 | Request continues a burst |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_ack | input | 1 | Memory returns `mem_rdata` this cycle |
| mem_rdata | input | 32 | Memory read data |
| inv_all | input | 1 | Invalidate every entry |
| inv_addr_req | input | 1 | Invalidate by line address |
| inv_line | input | 27 | Line address (byte address bits 31:5) |
| inv_sw_req | input | 1 | Invalidate one set/way entry |
| inv_set | input | 4 | Set for `inv_sw_req` |
| inv_way | input | 3 | Way for `inv_sw_req` |

## Verification
The hardest state to reach is a single set that holds several lines in different ways at once. Without it, selective invalidation and victim choice cannot be told apart from a full flush. The stimulus builds that state by filling two or three lines that share set 0, steering each into a different way with `victim_way`. It then removes one entry by address, by set and way, or with an out-of-range way. After each step it probes every resident line and counts memory beats to see which entries survived. Merged lanes from earlier write hits mark the surviving line, so a wrongly refilled entry shows up as changed data.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYPASS,
        ST_DONE
    } cstate_e;

    // Pull the requested lane out of a full word, zero-extended.
    function automatic logic [WORD_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] sz,
                                                    input logic [1:0] lo);
        logic [WORD_W-1:0] sh;
        case (sz)
            SZ_BYTE: begin
                sh = w >> {lo, 3'b000};
                return sh & 32'h0000_00FF;
            end
            SZ_HALF: begin
                sh = w >> {lo[1], 4'b0000};
                return sh & 32'h0000_FFFF;
            end
            default: return w;
        endcase
    endfunction

    // Byte-lane enables of a write.
    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 4'b0001 << lo;
            SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Replicate right-aligned write data across the word.
    function automatic logic [WORD_W-1:0] lane_data(input logic [1:0] sz,
                                                    input logic [WORD_W-1:0] wd);
        case (sz)
            SZ_BYTE: return {4{wd[7:0]}};
            SZ_HALF: return {2{wd[15:0]}};
            default: return wd;
        endcase
    endfunction

endpackage

// File: rtl/wt_cache_way.sv
module wt_cache_way #(
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 8,
    parameter int LINE_W     = 27,
    parameter int WAY_W      = 2,
    parameter int WAY_ID     = 0,
    localparam int IDX_W     = $clog2(SETS),
    localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic [WSEL_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [LINE_W-1:0] rd_line,
    output logic [WAY_W-1:0]  rd_way,
    output logic [31:0]       rd_data,
    input  logic              data_we,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic              tag_we,
    input  logic [LINE_W-1:0] tag_line,
    input  logic              inv_all,
    input  logic              inv_set_en,
    input  logic [IDX_W-1:0]  inv_set,
    input  logic              inv_line_en,
    input  logic [LINE_W-1:0] inv_line
);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [WAY_W-1:0]  way;
        logic              valid;
    } tag_ent_t;

    localparam int DEPTH = SETS * LINE_WORDS;

    tag_ent_t    tags_q [SETS];
    logic [31:0] data_q [DEPTH];

    logic [IDX_W-1:0] inv_idx;
    assign inv_idx = inv_line[IDX_W-1:0];

    assign rd_valid = tags_q[rd_set].valid;
    assign rd_line  = tags_q[rd_set].line;
    assign rd_way   = tags_q[rd_set].way;
    assign rd_data  = data_q[{rd_set, rd_word}];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tags_q[s].valid <= 1'b0;
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++) tags_q[s].valid <= 1'b0;
        end else if (inv_set_en) begin
            tags_q[inv_set].valid <= 1'b0;
        end else if (inv_line_en) begin
            if (tags_q[inv_idx].valid && tags_q[inv_idx].line == inv_line)
                tags_q[inv_idx].valid <= 1'b0;
        end else if (tag_we) begin
            tags_q[rd_set] <= '{line: tag_line, way: WAY_W'(WAY_ID), valid: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (data_we) begin
            for (int b = 0; b < 4; b++)
                if (wr_be[b]) data_q[{rd_set, wr_word}][8*b +: 8] <= wr_data[8*b +: 8];
        end
    end

endmodule

// File: rtl/wt_cache.sv
module wt_cache
    import wt_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int OFF_W     = WSEL_W + 2,
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int LINE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_cacheable,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    input  logic [WAY_W-1:0]  victim_way,
    output logic              mem_req,
    output logic              mem_seq,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              inv_all,
    input  logic              inv_addr_req,
    input  logic [LINE_W-1:0] inv_line,
    input  logic              inv_sw_req,
    input  logic [IDX_W-1:0]  inv_set,
    input  logic [WAY_W:0]    inv_way
);

    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

    cstate_e           state_q, state_d;
    logic [WSEL_W-1:0] cnt_q, cnt_d;
    logic [WAY_W-1:0]  vic_q, vic_d;
    logic [31:0]       rdata_q, rdata_d;

    logic [IDX_W-1:0]  cur_idx;
    logic [WSEL_W-1:0] cur_word;
    logic [LINE_W-1:0] cur_line;
    assign cur_idx  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
    assign cur_word = cpu_addr[OFF_W-1:2];
    assign cur_line = cpu_addr[ADDR_W-1:OFF_W];

    logic idle, inv_any, look_go;
    assign idle    = (state_q == ST_IDLE);
    assign inv_any = inv_all | inv_addr_req | inv_sw_req;
    assign look_go = idle && cpu_req && cpu_cacheable && !inv_any;

    logic [WAYS-1:0]   hit_vec;
    logic              rd_valid [WAYS];
    logic [LINE_W-1:0] rd_line  [WAYS];
    logic [WAY_W-1:0]  rd_way   [WAYS];
    logic [31:0]       rd_data  [WAYS];

    logic [WAYS-1:0]   dwe, twe;
    logic [WSEL_W-1:0] d_word;
    logic [3:0]        d_be;
    logic [31:0]       d_data;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wt_cache_way #(
            .SETS(SETS), .LINE_WORDS(LINE_WORDS), .LINE_W(LINE_W),
            .WAY_W(WAY_W), .WAY_ID(w)
        ) u_way (
            .clk        (clk),
            .rst        (rst),
            .rd_set     (cur_idx),
            .rd_word    (cur_word),
            .rd_valid   (rd_valid[w]),
            .rd_line    (rd_line[w]),
            .rd_way     (rd_way[w]),
            .rd_data    (rd_data[w]),
            .data_we    (dwe[w]),
            .wr_word    (d_word),
            .wr_be      (d_be),
            .wr_data    (d_data),
            .tag_we     (twe[w]),
            .tag_line   (cur_line),
            .inv_all    (inv_all && idle),
            .inv_set_en (inv_sw_req && idle && (inv_way == (WAY_W+1)'(w))),
            .inv_set    (inv_set),
            .inv_line_en(inv_addr_req && idle),
            .inv_line   (inv_line)
        );
        assign hit_vec[w] = rd_valid[w] && (rd_line[w] == cur_line);
    end

    // Hit data and the way number recorded in the hitting tag entry.
    logic [31:0]      hit_word;
    logic [WAY_W-1:0] hit_way;
    always_comb begin
        hit_word = '0;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_word = hit_word | rd_data[w];
                hit_way  = hit_way  | rd_way[w];
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        vic_d     = vic_q;
        rdata_d   = rdata_q;
        dwe       = '0;
        twe       = '0;
        d_word    = cur_word;
        d_be      = 4'b0000;
        d_data    = '0;
        mem_req   = 1'b0;
        mem_seq   = 1'b0;
        mem_addr  = '0;
        cpu_ready = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req && !inv_any) begin
                    if (!cpu_cacheable) begin
                        state_d = cpu_we ? ST_DONE : ST_BYPASS;
                    end else if (|hit_vec) begin
                        if (cpu_we) begin
                            dwe[hit_way] = 1'b1;
                            d_be         = lane_mask(cpu_size, cpu_addr[1:0]);
                            d_data       = lane_data(cpu_size, cpu_wdata);
                        end else begin
                            rdata_d = pick_lane(hit_word, cpu_size, cpu_addr[1:0]);
                        end
                        state_d = ST_DONE;
                    end else if (cpu_we) begin
                        state_d = ST_DONE;
                    end else begin
                        vic_d   = victim_way;
                        cnt_d   = '0;
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_seq  = (cnt_q != '0);
                mem_addr = {cur_line, cnt_q, 2'b00};
                if (mem_ack) begin
                    dwe[vic_q] = 1'b1;
                    d_word     = cnt_q;
                    d_be       = 4'b1111;
                    d_data     = mem_rdata;
                    if (cnt_q == cur_word)
                        rdata_d = pick_lane(mem_rdata, cpu_size, cpu_addr[1:0]);
                    if (cnt_q == LAST_WORD) begin
                        twe[vic_q] = 1'b1;
                        state_d    = ST_DONE;
                    end
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_BYPASS: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_addr[ADDR_W-1:2], 2'b00};
                if (mem_ack) begin
                    rdata_d = pick_lane(mem_rdata, cpu_size, cpu_addr[1:0]);
                    state_d = ST_DONE;
                end
            end
            default: begin
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            vic_q   <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            vic_q   <= vic_d;
            rdata_q <= rdata_d;
        end
    end

    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_seq,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              look_go,
    input logic [WAYS-1:0]   hit_vec
);

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (look_go && |hit_vec) |=> !mem_req);                         // R1

    AST_BURST_STARTS_NONSEQ: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> !mem_seq);                                // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));  // R2

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);                                   // R12

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));                                          // R13

endmodule

bind wt_cache wt_cache_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_seq  (mem_seq),
    .mem_addr (mem_addr),
    .look_go  (look_go),
    .hit_vec  (hit_vec)
);

// File: tb/wt_cache_bench.sv
`timescale 1ns/1ps
module wt_cache_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_cacheable = 1'b1;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic [1:0]  victim_way = '0;
    logic        mem_req, mem_seq, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        inv_all = 1'b0, inv_addr_req = 1'b0, inv_sw_req = 1'b0;
    logic [26:0] inv_line = '0;
    logic [3:0]  inv_set = '0;
    logic [2:0]  inv_way = '0;

    always #4 clk = ~clk;

    wt_cache u_wt_cache (.*);

    // Memory model: word at a is {~a[15:0], a[15:0]}; ack on every other cycle.
    function automatic logic [31:0] memf(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    logic ack_q;
    always @(posedge clk) ack_q <= rst ? 1'b0 : (mem_req && !ack_q);
    assign mem_ack   = mem_req && ack_q;
    assign mem_rdata = memf(mem_addr);

    int          nbeat = 0, nready = 0;
    logic [31:0] beat_addr [512];
    logic        beat_seq  [512];
    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (nbeat < 512) begin
                beat_addr[nbeat] <= mem_addr;
                beat_seq[nbeat]  <= mem_seq;
            end
            nbeat <= nbeat + 1;
        end
        if (!rst && cpu_ready) nready <= nready + 1;
    end

    int  ntest = 0, nfail = 0;
    bit  finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic c, input logic we, input logic [1:0] sz,
                          input logic [1:0] vic, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int beats, output int base_beat);
        int nr0;
        int guard;
        @(negedge clk);
        base_beat = nbeat;
        nr0 = nready;
        cpu_cacheable = c; cpu_we = we; cpu_size = sz; victim_way = vic;
        cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!cpu_ready && guard < 200);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        beats = nbeat - base_beat;
        check("R12 one ready pulse per access", 32'(nready - nr0), 32'd1);
    endtask

    task automatic check_fill(input string tag, input logic [31:0] a, input int b0);
        logic [31:0] base;
        bit ok;
        base = a & ~32'h1F;
        ok = 1;
        for (int i = 0; i < 8; i++)
            if (beat_addr[b0+i] !== base + 32'(4*i) || beat_seq[b0+i] !== (i != 0)) ok = 0;
        check(tag, {31'd0, ok}, 32'd1);
    endtask

    // Read and check data and beat count in one go.
    task automatic rd_chk(input string tag, input logic [1:0] vic, input logic [31:0] a,
                          input logic [31:0] exp, input int exp_beats);
        logic [31:0] rd;
        int beats, b0;
        access(1'b1, 1'b0, 2'd2, vic, a, 32'd0, rd, beats, b0);
        check({tag, " data"}, rd, exp);
        check({tag, " beats"}, 32'(beats), 32'(exp_beats));
        if (exp_beats == 8) check_fill({tag, " burst"}, a, b0);
    endtask

    task automatic pulse_inv(input int kind);
        @(negedge clk);
        case (kind)
            0: inv_all = 1'b1;
            1: inv_addr_req = 1'b1;
            default: inv_sw_req = 1'b1;
        endcase
        @(negedge clk);
        inv_all = 1'b0; inv_addr_req = 1'b0; inv_sw_req = 1'b0;
    endtask

    typedef struct packed {
        logic        c;
        logic        we;
        logic [1:0]  sz;
        logic [1:0]  vic;
        logic [31:0] a;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  beats;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t VECS [17] = '{
        '{1'b1, 1'b0, 2'd2, 2'd0, 32'h1004, 32'h0,        32'hEFFB1004, 8'd8, 8'd2 },  // R2 R3 miss fill
        '{1'b1, 1'b0, 2'd2, 2'd0, 32'h1010, 32'h0,        32'hEFEF1010, 8'd0, 8'd1 },  // R1 R3 hit
        '{1'b1, 1'b0, 2'd0, 2'd0, 32'h1011, 32'h0,        32'h00000010, 8'd0, 8'd4 },  // R4 byte lane 1
        '{1'b1, 1'b0, 2'd0, 2'd0, 32'h1013, 32'h0,        32'h000000EF, 8'd0, 8'd4 },  // R4 byte lane 3
        '{1'b1, 1'b0, 2'd1, 2'd0, 32'h1012, 32'h0,        32'h0000EFEF, 8'd0, 8'd5 },  // R5 upper half
        '{1'b1, 1'b0, 2'd1, 2'd0, 32'h1010, 32'h0,        32'h00001010, 8'd0, 8'd5 },  // R5 lower half
        '{1'b1, 1'b1, 2'd0, 2'd0, 32'h1015, 32'h000000AB, 32'h0,        8'd0, 8'd6 },  // R6 byte write
        '{1'b1, 1'b0, 2'd2, 2'd0, 32'h1014, 32'h0,        32'hEFEBAB14, 8'd0, 8'd6 },  // R6
        '{1'b1, 1'b1, 2'd1, 2'd0, 32'h1016, 32'h00001234, 32'h0,        8'd0, 8'd6 },  // R6 half write
        '{1'b1, 1'b0, 2'd2, 2'd0, 32'h1014, 32'h0,        32'h1234AB14, 8'd0, 8'd6 },  // R6
        '{1'b1, 1'b1, 2'd2, 2'd0, 32'h1018, 32'hCAFEF00D, 32'h0,        8'd0, 8'd6 },  // R6 word write
        '{1'b1, 1'b0, 2'd2, 2'd0, 32'h1018, 32'h0,        32'hCAFEF00D, 8'd0, 8'd6 },  // R6
        '{1'b1, 1'b1, 2'd2, 2'd0, 32'h2008, 32'hDEADBEEF, 32'h0,        8'd0, 8'd7 },  // R7 write miss
        '{1'b1, 1'b0, 2'd2, 2'd1, 32'h2008, 32'h0,        32'hDFF72008, 8'd8, 8'd7 },  // R7 then fill way 1
        '{1'b1, 1'b0, 2'd2, 2'd0, 32'h1014, 32'h0,        32'h1234AB14, 8'd0, 8'd13},  // R13 way 0 kept
        '{1'b0, 1'b0, 2'd2, 2'd0, 32'h1014, 32'h0,        32'hEFEB1014, 8'd1, 8'd8 },  // R8 uncached read
        '{1'b0, 1'b1, 2'd2, 2'd0, 32'h1014, 32'h00000000, 32'h0,        8'd0, 8'd8 }   // R8 uncached write
    };

    initial begin
        logic [31:0] rd;
        int beats, b0;
        repeat (3) @(negedge clk);
        check("R12 ready low in reset", {31'd0, cpu_ready}, 32'd0);
        check("R2 no memory request in reset", {31'd0, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 17; i++) begin
            access(VECS[i].c, VECS[i].we, VECS[i].sz, VECS[i].vic, VECS[i].a, VECS[i].wd,
                   rd, beats, b0);
            if (!VECS[i].we)
                check($sformatf("R%0d vector %0d data", VECS[i].rq, i), rd, VECS[i].exp);
            check($sformatf("R%0d vector %0d beats", VECS[i].rq, i), 32'(beats), 32'(VECS[i].beats));
            if (VECS[i].beats == 8) check_fill($sformatf("R2 vector %0d burst", i), VECS[i].a, b0);
            if (VECS[i].beats == 1) begin
                check("R8 bypass address", beat_addr[b0], VECS[i].a & ~32'h3);
                check("R8 bypass nonsequential", {31'd0, beat_seq[b0]}, 32'd0);
            end
        end
        rd_chk("R8 cache unchanged after uncached write", 2'd0, 32'h1014, 32'h1234AB14, 0);

        // Set 0 holds 0x1000 (way 0) and 0x2000 (way 1).
        inv_line = 27'(32'h2000 >> 5);
        pulse_inv(1);
        rd_chk("R10 other way still hits", 2'd0, 32'h1014, 32'h1234AB14, 0);
        rd_chk("R10 matching line gone", 2'd2, 32'h2008, 32'hDFF72008, 8);

        inv_set = 4'd0; inv_way = 3'd4;
        pulse_inv(2);
        rd_chk("R11 way 4 ignored", 2'd0, 32'h1014, 32'h1234AB14, 0);
        inv_way = 3'd0;
        pulse_inv(2);
        rd_chk("R11 set 0 way 0 cleared", 2'd0, 32'h1014, 32'hEFEB1014, 8);
        rd_chk("R11 way 2 untouched", 2'd0, 32'h2008, 32'hDFF72008, 0);

        pulse_inv(0);
        rd_chk("R9 invalidate all line A", 2'd3, 32'h2008, 32'hDFF72008, 8);
        rd_chk("R9 invalidate all line B", 2'd1, 32'h1014, 32'hEFEB1014, 8);
        rd_chk("R13 fill into way 1 kept way 3", 2'd0, 32'h2008, 32'hDFF72008, 0);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 ready low under reset", {31'd0, cpu_ready}, 32'd0);
        rst = 1'b0;
        rd_chk("R9 reset clears valid", 2'd0, 32'h1014, 32'hEFEB1014, 8);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            ntest++;
            nfail++;
            $display("FAIL R12 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

endmodule